// File: doc/BRIEF.md
# APB Register Target with Programmable Wait States

This block is an APB subordinate that holds a bank of eight 32-bit registers and answers slowly on purpose. A 3-bit wait-count input selects how many access cycles the target keeps its ready output low before it completes. This lets the block stand in for a slow register or for a target that sits across a clock boundary. A count of zero gives a fast target that completes in its first access cycle.

The block is built around one rule. A write lands in a register, and read data appears on the bus, only in the single cycle where select, enable and ready are all high. Setup cycles and wait cycles commit nothing. The read-data output stays at zero in every other cycle. This makes a design that samples too early, or that captures on the first enable cycle, easy to see.

A three-state machine controls the sequencing. ST_IDLE waits for a setup cycle (select high, enable low). On that cycle it loads the wait counter from the wait-count input. It moves to ST_WAIT when the count is non-zero and to ST_READY when the count is zero. ST_WAIT counts down once per access cycle and moves to ST_READY when the last wait cycle has elapsed. ST_READY raises ready in the access cycle, which is the completion, and then returns to ST_IDLE. From ST_WAIT or ST_READY, a drop of select abandons the transfer and returns the machine to ST_IDLE.

Top module: `apb_waitreg_slave`

## Requirements
- R1: After reset, ready and read data are 0, and each of the eight registers reads back as 0.
- R2: With a wait count N from 1 to 7 presented on the setup cycle, ready is low for exactly N access cycles and goes high on access cycle N+1.
- R3: With a wait count of 0 on the setup cycle, ready is high in the first access cycle.
- R4: A write changes a register only in the cycle where select, enable, ready and write are all high. That register is the one selected by address bits [4:2].
- R5: In a setup cycle (select high, enable low), and whenever select is low, ready is 0 and no register changes.
- R6: On a read completion cycle, read data equals the addressed register. In every other cycle (setup, wait, idle, write completion) read data is 0.
- R7: The wait count is taken only on the setup cycle. Changing the wait-count input during the access phase does not change how long that transfer lasts.
- R8: If select drops before completion, the transfer ends without changing any register, and the next transfer runs normally.
- R9: A setup cycle may follow a completion cycle directly, and the second transfer then keeps its own wait count and data.
- R10: Address bits other than [4:2] are ignored. For example, address 0xE4 reaches the same register as address 0x04.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low reset |
| psel | input | 1 | Target select |
| penable | input | 1 | Access phase marker |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | ADDR_W (8) | Byte address; bits [4:2] pick the register |
| pwdata | input | DATA_W (32) | Write data |
| wait_cfg | input | WAIT_W (3) | Number of wait cycles for the next transfer |
| pready | output | 1 | Completion (high) or hold (low) |
| prdata | output | DATA_W (32) | Read data, non-zero only on a read completion |

## Verification
The wait counter can get two inputs in the same cycle: the value it holds and counts down, and a new value that arrives on the wait-count input during an access cycle. The test provokes this by driving the wait-count input to 7 during the wait cycles of a transfer that was set up with a count of 2. It then judges the result by the number of low-ready cycles, which must still be 2. A second pair of events also meets in one edge: a write completion and the setup of the next transfer. Back-to-back transfers that immediately read the register just written check both.

// File: rtl/apb_waitreg_pkg.sv
package apb_waitreg_pkg;

    // Sequencer states of the wait-state target.
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_WAIT  = 2'd1,
        ST_READY = 2'd2
    } wr_state_e;

    // Byte offset of the register index inside the address.
    localparam int unsigned WORD_SHIFT = 2;

endpackage

// File: rtl/apb_waitreg_fsm.sv
module apb_waitreg_fsm
    import apb_waitreg_pkg::*;
#(
    parameter int unsigned WAIT_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              psel,
    input  logic              penable,
    input  logic [WAIT_W-1:0] wait_cfg,
    output logic              pready
);

    localparam logic [WAIT_W-1:0] CNT_ZERO = '0;
    localparam logic [WAIT_W-1:0] CNT_ONE  = {{(WAIT_W-1){1'b0}}, 1'b1};

    wr_state_e         state_q, state_d;
    logic [WAIT_W-1:0] cnt_q, cnt_d;
    logic              setup_cyc;
    logic              access_cyc;

    assign setup_cyc  = psel && !penable;
    assign access_cyc = psel && penable;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= CNT_ZERO;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // Transitions and outputs
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        pready  = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (setup_cyc) begin
                    cnt_d   = wait_cfg;
                    state_d = (wait_cfg == CNT_ZERO) ? ST_READY : ST_WAIT;
                end
            end
            ST_WAIT: begin
                if (!psel) begin
                    state_d = ST_IDLE;
                    cnt_d   = CNT_ZERO;
                end else if (access_cyc) begin
                    cnt_d = cnt_q - CNT_ONE;
                    if (cnt_q == CNT_ONE) begin
                        state_d = ST_READY;
                    end
                end
            end
            ST_READY: begin
                if (!psel) begin
                    state_d = ST_IDLE;
                end else if (access_cyc) begin
                    pready  = 1'b1;
                    state_d = ST_IDLE;
                end
            end
            default: begin
                state_d = ST_IDLE;
                cnt_d   = CNT_ZERO;
            end
        endcase
    end

endmodule

// File: rtl/apb_waitreg_bank.sv
module apb_waitreg_bank #(
    parameter int unsigned NUM_REGS = 8,
    parameter int unsigned DATA_W   = 32,
    localparam int unsigned IDX_W   = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         wr_en,
    input  logic [IDX_W-1:0]             wr_idx,
    input  logic [DATA_W-1:0]            wr_data,
    output logic [NUM_REGS*DATA_W-1:0]   reg_flat
);

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
        logic hit;
        assign hit = wr_en && (wr_idx == IDX_W'(g));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                reg_flat[g*DATA_W +: DATA_W] <= '0;
            end else if (hit) begin
                reg_flat[g*DATA_W +: DATA_W] <= wr_data;
            end
        end
    end

endmodule

// File: rtl/apb_waitreg_rdmux.sv
module apb_waitreg_rdmux #(
    parameter int unsigned NUM_REGS = 8,
    parameter int unsigned DATA_W   = 32,
    localparam int unsigned IDX_W   = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
    input  logic [NUM_REGS*DATA_W-1:0] reg_flat,
    input  logic [IDX_W-1:0]           rd_idx,
    input  logic                       rd_en,
    output logic [DATA_W-1:0]          rdata
);

    logic [DATA_W-1:0] sel_word;

    always_comb begin
        sel_word = '0;
        for (int i = 0; i < NUM_REGS; i++) begin
            if (rd_idx == IDX_W'(i)) begin
                sel_word = reg_flat[i*DATA_W +: DATA_W];
            end
        end
    end

    // Data leaves the block only on a read completion.
    assign rdata = rd_en ? sel_word : '0;

endmodule

// File: rtl/apb_waitreg_slave.sv
module apb_waitreg_slave
    import apb_waitreg_pkg::*;
#(
    parameter int unsigned ADDR_W   = 8,
    parameter int unsigned DATA_W   = 32,
    parameter int unsigned NUM_REGS = 8,
    parameter int unsigned WAIT_W   = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [ADDR_W-1:0] paddr,
    input  logic [DATA_W-1:0] pwdata,
    input  logic [WAIT_W-1:0] wait_cfg,
    output logic              pready,
    output logic [DATA_W-1:0] prdata
);

    localparam int unsigned IDX_W  = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;
    localparam int unsigned IDX_LO = WORD_SHIFT;
    localparam int unsigned IDX_HI = WORD_SHIFT + IDX_W - 1;

    logic                       commit;
    logic [IDX_W-1:0]           reg_idx;
    logic [NUM_REGS*DATA_W-1:0] reg_flat;
    logic                       unused_addr_bits;

    assign reg_idx          = paddr[IDX_HI:IDX_LO];
    assign unused_addr_bits = ^{paddr[ADDR_W-1:IDX_HI+1], paddr[IDX_LO-1:0]};

    // The one completion cycle of a transfer.
    assign commit = psel && penable && pready;

    apb_waitreg_fsm #(
        .WAIT_W (WAIT_W)
    ) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .psel     (psel),
        .penable  (penable),
        .wait_cfg (wait_cfg),
        .pready   (pready)
    );

    apb_waitreg_bank #(
        .NUM_REGS (NUM_REGS),
        .DATA_W   (DATA_W)
    ) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (commit && pwrite),
        .wr_idx   (reg_idx),
        .wr_data  (pwdata),
        .reg_flat (reg_flat)
    );

    apb_waitreg_rdmux #(
        .NUM_REGS (NUM_REGS),
        .DATA_W   (DATA_W)
    ) u_rdmux (
        .reg_flat (reg_flat),
        .rd_idx   (reg_idx),
        .rd_en    (commit && !pwrite),
        .rdata    (prdata)
    );

endmodule

// File: rtl/apb_waitreg_chk.sv
module apb_waitreg_chk #(
    parameter int unsigned DATA_W   = 32,
    parameter int unsigned NUM_REGS = 8,
    parameter int unsigned WAIT_W   = 3
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       psel,
    input logic                       penable,
    input logic                       pwrite,
    input logic [WAIT_W-1:0]          wait_cfg,
    input logic                       pready,
    input logic [DATA_W-1:0]          prdata,
    input logic [NUM_REGS*DATA_W-1:0] reg_flat
);

    assert_setup_not_ready_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!psel || !penable) |-> !pready);

    assert_rdata_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(pready && !pwrite) |-> (prdata == '0));

    assert_single_completion_R2: assert property (@(posedge clk) disable iff (!rst_n)
        pready |=> !pready);

    assert_zero_wait_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (psel && !penable && wait_cfg == '0) ##1 (psel && penable) |-> pready);

    assert_no_early_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !(psel && penable && pready && pwrite) |=> $stable(reg_flat));

endmodule

bind apb_waitreg_slave apb_waitreg_chk #(
    .DATA_W   (DATA_W),
    .NUM_REGS (NUM_REGS),
    .WAIT_W   (WAIT_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .psel     (psel),
    .penable  (penable),
    .pwrite   (pwrite),
    .wait_cfg (wait_cfg),
    .pready   (pready),
    .prdata   (prdata),
    .reg_flat (reg_flat)
);

// File: tb/apb_waitreg_slave_tb.sv
module apb_waitreg_slave_tb;

    localparam int CLK_PERIOD = 10;
    localparam int N_VEC      = 10;

    typedef struct packed {
        logic        wr;
        logic [7:0]  addr;
        logic [31:0] data;
        logic [2:0]  waits;
    } vec_t;

    localparam vec_t VECS [N_VEC] = '{
        '{1'b1, 8'h00, 32'hDEADBEEF, 3'd0},
        '{1'b1, 8'h1C, 32'h12345678, 3'd3},
        '{1'b0, 8'h00, 32'h0,        3'd1},
        '{1'b0, 8'h1C, 32'h0,        3'd7},
        '{1'b1, 8'h08, 32'hA5A5A5A5, 3'd7},
        '{1'b0, 8'h08, 32'h0,        3'd0},
        '{1'b0, 8'h04, 32'h0,        3'd2},
        '{1'b1, 8'h10, 32'h0F0F0000, 3'd5},
        '{1'b0, 8'h10, 32'h0,        3'd4},
        '{1'b1, 8'hE4, 32'hCAFEF00D, 3'd1}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        psel = 1'b0;
    logic        penable = 1'b0;
    logic        pwrite = 1'b0;
    logic [7:0]  paddr = '0;
    logic [31:0] pwdata = '0;
    logic [2:0]  wait_cfg = '0;
    logic        pready;
    logic [31:0] prdata;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;
    logic [31:0] model [8];

    always #(CLK_PERIOD/2) clk = ~clk;

    apb_waitreg_slave u_dut (
        .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable),
        .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata),
        .wait_cfg(wait_cfg), .pready(pready), .prdata(prdata)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // One transfer. mid_cfg is driven on wait_cfg during the access phase.
    task automatic xfer(input logic wr, input logic [7:0] a, input logic [31:0] d,
                        input logic [2:0] w, input logic [2:0] mid_cfg,
                        output int nwait, output logic [31:0] rd);
        @(negedge clk);
        psel = 1'b1; penable = 1'b0; pwrite = wr; paddr = a; pwdata = d;
        wait_cfg = w;
        #1;
        check(pready == 1'b0, "R5 setup ready", 32'(pready), 32'd0);
        check(prdata == '0, "R6 setup rdata", prdata, 32'd0);
        @(negedge clk);
        penable = 1'b1;
        wait_cfg = mid_cfg;
        nwait = 0;
        rd = '0;
        for (int k = 0; k < 20; k++) begin
            #1;
            if (pready) begin
                rd = prdata;
                break;
            end
            check(prdata == '0, "R6 wait rdata", prdata, 32'd0);
            nwait++;
            @(negedge clk);
        end
        if (wr) begin
            model[a[4:2]] = d;
            check(rd == '0, "R6 write completion rdata", rd, 32'd0);
        end
    endtask

    task automatic go_idle();
        @(negedge clk);
        psel = 1'b0; penable = 1'b0; pwdata = 32'h5555AAAA;
        #1;
        check(pready == 1'b0, "R5 idle ready", 32'(pready), 32'd0);
        check(prdata == '0, "R6 idle rdata", prdata, 32'd0);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin : main
        int nw;
        logic [31:0] rd;
        for (int i = 0; i < 8; i++) model[i] = '0;

        repeat (3) @(posedge clk);
        #1;
        check(pready == 1'b0, "R1 reset ready", 32'(pready), 32'd0);
        check(prdata == '0, "R1 reset rdata", prdata, 32'd0);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: every register reads zero after reset
        for (int i = 0; i < 8; i++) begin
            xfer(1'b0, 8'(i*4), '0, 3'd0, 3'd0, nw, rd);
            check(rd == '0, "R1 reset register value", rd, 32'd0);
        end
        go_idle();

        // Vector table: back-to-back transfers (R2, R3, R4, R6, R9, R10)
        for (int v = 0; v < N_VEC; v++) begin
            logic [31:0] exp;
            exp = model[VECS[v].addr[4:2]];
            xfer(VECS[v].wr, VECS[v].addr, VECS[v].data, VECS[v].waits,
                 VECS[v].waits, nw, rd);
            check(nw == int'(VECS[v].waits), "R2 R3 R9 wait cycles",
                  32'(nw), 32'(VECS[v].waits));
            if (!VECS[v].wr)
                check(rd == exp, "R6 R4 read data", rd, exp);
        end
        go_idle();

        // R10: 0xE4 wrote register 1; read it through 0x04
        xfer(1'b0, 8'h04, '0, 3'd0, 3'd0, nw, rd);
        check(rd == 32'hCAFEF00D, "R10 address alias", rd, 32'hCAFEF00D);
        go_idle();

        // R7: wait_cfg changes during access do not stretch the transfer
        xfer(1'b1, 8'h0C, 32'h77778888, 3'd2, 3'd7, nw, rd);
        check(nw == 2, "R7 wait count latched at setup", 32'(nw), 32'd2);
        xfer(1'b0, 8'h0C, '0, 3'd6, 3'd0, nw, rd);
        check(nw == 6, "R7 wait count latched at setup", 32'(nw), 32'd6);
        check(rd == 32'h77778888, "R7 read data", rd, 32'h77778888);
        go_idle();

        // R8 and R4: abandon a write after two wait cycles
        @(negedge clk);
        psel = 1'b1; penable = 1'b0; pwrite = 1'b1; paddr = 8'h18;
        pwdata = 32'hBAD0BAD0; wait_cfg = 3'd3;
        @(negedge clk);
        penable = 1'b1;
        @(negedge clk);
        #1;
        check(pready == 1'b0, "R8 still waiting", 32'(pready), 32'd0);
        go_idle();
        xfer(1'b0, 8'h18, '0, 3'd1, 3'd1, nw, rd);
        check(rd == 32'h0, "R8 R4 abandoned write not committed", rd, 32'h0);
        check(nw == 1, "R8 next transfer wait cycles", 32'(nw), 32'd1);

        // R4: a completed write with wait states commits the held data
        xfer(1'b1, 8'h18, 32'h13579BDF, 3'd4, 3'd4, nw, rd);
        xfer(1'b0, 8'h18, '0, 3'd0, 3'd0, nw, rd);
        check(rd == 32'h13579BDF, "R4 write after waits", rd, 32'h13579BDF);
        check(nw == 0, "R3 zero wait", 32'(nw), 32'd0);
        go_idle();

        // R5: setup cycle alone (no access phase) commits nothing
        @(negedge clk);
        psel = 1'b1; penable = 1'b0; pwrite = 1'b1; paddr = 8'h14;
        pwdata = 32'hFFFFFFFF; wait_cfg = 3'd0;
        go_idle();
        xfer(1'b0, 8'h14, '0, 3'd0, 3'd0, nw, rd);
        check(rd == 32'h0, "R5 setup only no commit", rd, 32'h0);
        go_idle();

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule